// File: doc/BRIEF.md
# Multimode UART with Address Marker

This block is a serial transceiver configured through four byte-wide registers on a simple read/write bus. It has three operating modes. The plain asynchronous mode frames 7 or 8 data bits with a start bit, optional parity and one or two stop bits. The multiprocessor mode sends 8 data bits followed by a marker bit that tells address frames from data frames. The clocked mode shifts 8 bits out on `txd` and in on `rxd`, and drives a shift clock on `sclk`. Bit timing comes from a single clock-enable input, `tick`, which pulses at 16 times the bit rate.

Software writes a byte to the data register to start a transmission and reads the same address to collect a received byte. Receive errors collect in the status register until software clears them through the control register. Two interrupt outputs report that a received byte or an error is pending, and that the transmit holding register is free. Clearing either enable bit stops that direction only after the frame in progress has finished.

Top module: `tri_mode_uart`

## Requirements
- R1: After reset, status (address 2) reads 0x10, control (address 0) reads 0x20, `txd` and `sclk` are high, and both interrupts are low.
- R2: The registers are laid out as follows. Address 0 is control: bit0 parity on, bit1 odd parity, bit2 two stop bits, bit3 8-bit length, bit4 address marker, bit5 error clear, bit6 receive enable, bit7 transmit enable. Address 1 is mode: bits[1:0] mode (00 async, 01 multiprocessor, 1x clocked), bit2 receive interrupt enable, bit3 transmit interrupt enable. Address 2 is status: bit0 framing error, bit1 overrun, bit2 parity error, bit3 receive full, bit4 transmit empty, bit5 received marker. Address 3 is data.
- R3: An asynchronous frame is a low start bit, the data bits LSB first (7 when bit3 is 0 in mode 00, otherwise 8), the optional parity or marker bit, then one or two high stop bits. Each bit lasts 16 ticks. A frame starts on the cycle after the data write when the transmitter is idle, and frames sent back to back are separated by one idle cycle.
- R4: Parity applies only in mode 00. With even parity the data bits and the parity bit together hold an even number of ones; with odd parity they hold an odd number.
- R5: Mode 01 forces 8 data bits and ignores parity. After the data the transmitter sends control bit4 as the marker. The receiver places the marker bit it receives in status bit5.
- R6: The clocked mode sends 8 bits LSB first with no start or stop bit. `sclk` is low for the first 8 ticks of each bit and high for the last 8. `rxd` is sampled at the rising edge of `sclk`, and the byte is stored if receive was enabled when the transfer began.
- R7: The receiver starts on a falling edge of `rxd`, confirms the start bit on the 8th tick and samples each later bit at its centre. It then stores the byte and sets receive full. Reading the data address clears receive full.
- R8: Only the first stop bit is sampled, whatever the stop length setting. If it is low, the framing error flag is set.
- R9: In mode 00 with parity on, a received parity bit that does not match the parity rule sets the parity error flag.
- R10: A frame that completes while receive full is still set sets the overrun flag. That frame is discarded and the older byte is kept.
- R11: Writing control with bit5 = 0 clears the framing, overrun and parity flags. Writing bit5 = 1 leaves them unchanged. Bit5 always reads as 1.
- R12: If receive enable is cleared while a frame is arriving, that frame is still stored, and no later frame is accepted.
- R13: If transmit enable is cleared during a frame, that frame finishes. A byte written afterwards waits, and transmit empty stays low, until transmit is enabled again.
- R14: `rx_irq` is high when the receive interrupt enable is set and receive full or any error flag is set. `tx_irq` is high when the transmit interrupt enable is set and transmit empty is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| sclk | output | 1 | Shift clock in clocked mode, idle high |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that the bus leaves the configuration alone while a frame is in flight, apart from the enable bits, and that no new data byte is written while the transmit holding register is full. The bench follows both rules: it waits for its own model of the transmitter to drain before it reconfigures anything, and it writes the next byte only after the model reports the holding register empty. Receive frames are driven at exactly 16 ticks per bit with `tick` held high. In the clocked mode `rxd` is looped back from `txd`, so every sample lands well inside a stable bit.

// File: rtl/tri_mode_uart.sv
module tri_mode_uart #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       sclk,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  logic [7:0] ctl;
  logic [3:0] mctl;

  wire pen   = ctl[0];
  wire odd   = ctl[1];
  wire two   = ctl[2];
  wire len8  = ctl[3];
  wire mark  = ctl[4];
  wire rxen  = ctl[6];
  wire txen  = ctl[7];
  wire m_sync = mctl[1];
  wire m_mp   = (mctl[1:0] == 2'b01);
  wire pen_e  = pen & (mctl[1:0] == 2'b00);
  wire n8     = len8 | (mctl[1:0] != 2'b00);
  wire has_x  = m_mp | pen_e;
  wire rx_ie  = mctl[2];
  wire tx_ie  = mctl[3];

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire rd_data = rd_en && addr == 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      mctl <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) ctl <= {wdata[7:6], 1'b0, wdata[4:0]};
      if (addr == 2'd1) mctl <= wdata[3:0];
    end
  end

  logic [1:0] rsync_ff;
  always_ff @(posedge clk) begin
    if (!rst_n) rsync_ff <= 2'b11;
    else        rsync_ff <= {rsync_ff[0], rxd};
  end
  wire rxs = rsync_ff[1];

  logic [7:0]    tdr;
  logic          tfull, tbusy, tsync, rsync;
  logic [11:0]   tsh, tframe;
  logic [3:0]    tleft, tlen, pos;
  logic [CW-1:0] tcnt;
  logic [7:0]    rsh;
  logic          xbit;

  assign pos  = n8 ? 4'd9 : 4'd8;
  assign xbit = m_mp ? mark : ((^(n8 ? tdr : {1'b0, tdr[6:0]})) ^ odd);
  assign tlen = m_sync ? 4'd8
              : 4'd2 + (n8 ? 4'd8 : 4'd7) + {3'b0, has_x} + {3'b0, two};

  always_comb begin
    tframe = '1;
    if (m_sync) tframe[7:0] = tdr;
    else begin
      if (n8) tframe[8:0] = {tdr, 1'b0};
      else    tframe[7:0] = {tdr[6:0], 1'b0};
      if (has_x) tframe[pos] = xbit;
    end
  end

  wire load      = !tbusy && tfull && txen;
  wire sync_smp  = tbusy && rsync && tick && tcnt == MID;
  wire sync_done = sync_smp && tleft == 4'd1;
  wire [7:0] sync_byte = {rxs, rsh[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdr <= '0; tfull <= 1'b0; tbusy <= 1'b0; tsync <= 1'b0; rsync <= 1'b0;
      tsh <= '1; tleft <= '0; tcnt <= '0; rsh <= '0;
    end else begin
      if (load) begin
        tsh   <= tframe;
        tleft <= tlen;
        tcnt  <= '0;
        tbusy <= 1'b1;
        tsync <= m_sync;
        rsync <= m_sync & rxen;
        tfull <= 1'b0;
      end else if (tbusy && tick) begin
        if (sync_smp) rsh <= sync_byte;
        if (tcnt == LAST) begin
          tcnt  <= '0;
          tsh   <= {1'b1, tsh[11:1]};
          tleft <= tleft - 4'd1;
          if (tleft == 4'd1) tbusy <= 1'b0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (wr_en && addr == 2'd3) begin
        tdr   <= wdata;
        tfull <= 1'b1;
      end
    end
  end

  assign txd  = tbusy ? tsh[0] : 1'b1;
  assign sclk = !(tbusy && tsync && tcnt <= MID);

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_t;
  rx_st_t        rst;
  logic          rprev;
  logic [CW-1:0] rcnt;
  logic [3:0]    ridx, sidx;
  logic [9:0]    rbuf;

  assign sidx = (n8 ? 4'd8 : 4'd7) + {3'b0, has_x};
  wire rx_idle    = (rst == R_IDLE);
  wire async_done = (rst == R_BITS) && tick && rcnt == LAST && ridx == sidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst <= R_IDLE; rprev <= 1'b1; rcnt <= '0; ridx <= '0; rbuf <= '0;
    end else if (tick) begin
      rprev <= rxs;
      case (rst)
        R_IDLE:
          if (rxen && !m_sync && rprev && !rxs) begin
            rst  <= R_START;
            rcnt <= '0;
          end
        R_START:
          if (rcnt == MID) begin
            rcnt <= '0;
            ridx <= '0;
            rst  <= rxs ? R_IDLE : R_BITS;
          end else rcnt <= rcnt + 1'b1;
        R_BITS:
          if (rcnt == LAST) begin
            rcnt <= '0;
            if (ridx == sidx) rst <= R_IDLE;
            else begin
              rbuf[ridx] <= rxs;
              ridx <= ridx + 4'd1;
            end
          end else rcnt <= rcnt + 1'b1;
        default: rst <= R_IDLE;
      endcase
    end
  end

  wire [7:0] adata = n8 ? rbuf[7:0] : {1'b0, rbuf[6:0]};
  wire       xb    = n8 ? rbuf[8] : rbuf[7];
  wire       perr  = xb != ((^adata) ^ odd);

  wire       done  = async_done | sync_done;
  wire [7:0] nbyte = sync_done ? sync_byte : adata;
  wire       nmark = async_done & m_mp & xb;
  wire       nfe   = async_done & !rxs;
  wire       npe   = async_done & pen_e & perr;

  logic [7:0] rdr;
  logic       rfull, rmark, fre, ore, pe;
  wire        ovr = rfull && !rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdr <= '0; rfull <= 1'b0; rmark <= 1'b0; fre <= 1'b0; ore <= 1'b0; pe <= 1'b0;
    end else begin
      if (wr_ctl && !wdata[5]) begin
        fre <= 1'b0; ore <= 1'b0; pe <= 1'b0;
      end
      if (rd_data) rfull <= 1'b0;
      if (done) begin
        if (ovr) ore <= 1'b1;
        else begin
          rdr   <= nbyte;
          rmark <= nmark;
          rfull <= 1'b1;
          if (nfe) fre <= 1'b1;
          if (npe) pe  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {ctl[7:6], 1'b1, ctl[4:0]};
      2'd1:    rdata = {4'b0, mctl};
      2'd2:    rdata = {2'b0, rmark, ~tfull, rfull, pe, ore, fre};
      default: rdata = rdr;
    endcase
  end

  assign rx_irq = rx_ie & (rfull | fre | ore | pe);
  assign tx_irq = tx_ie & ~tfull;
endmodule

module tri_mode_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       txen,
  input logic       rxen,
  input logic       tbusy,
  input logic       rfull,
  input logic [7:0] rdr,
  input logic       fre,
  input logic       ore,
  input logic       pe,
  input logic       done,
  input logic       async_done,
  input logic       rxs,
  input logic       rx_idle,
  input logic       txd
);
  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wdata[5] && !done) |=> !(fre || ore || pe));
  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rfull && !(rd_en && addr == 2'd3)) |=> (ore && $stable(rdr)));
  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbusy && !txen) |=> !tbusy);
  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_idle && !rxen) |=> rx_idle);
  // R8
  framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_done && !rxs && !rfull) |=> fre);
  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tbusy) |-> txd);
  // R7
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rfull);
endmodule

bind tri_mode_uart tri_mode_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .txen(txen), .rxen(rxen), .tbusy(tbusy), .rfull(rfull),
  .rdr(rdr), .fre(fre), .ore(ore), .pe(pe), .done(done),
  .async_done(async_done), .rxs(rxs), .rx_idle(rx_idle), .txd(txd)
);

// File: tb/test_tri_mode_uart.sv
module test_tri_mode_uart;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, sclk, rx_irq, tx_irq;
  logic rxd_drv = 1'b1, loop = 1'b0;
  wire  rxd = loop ? txd : rxd_drv;

  int total = 0, bad = 0, cycles = 0;
  string cur = "R1";

  tri_mode_uart i_tri_mode_uart (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .sclk(sclk), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural transmitter model: queue of {sclk, txd} per cycle
  logic [7:0] m_ctl = '0, m_mctl = '0, m_tdr = '0;
  bit m_full = 0;
  logic [1:0] q[$];
  logic [1:0] exp_pins = 2'b11;

  function automatic void push_bit(bit b, bit syn);
    for (int k = 0; k < 16; k++) q.push_back({syn ? (k >= 8) : 1'b1, b});
  endfunction

  function automatic void build();
    bit syn = m_mctl[1];
    bit mp  = (m_mctl[1:0] == 2'b01);
    bit pe_on = m_ctl[0] && m_mctl[1:0] == 2'b00;
    int n = (m_mctl[1:0] == 2'b00 && !m_ctl[3]) ? 7 : 8;
    int ones = 0;
    if (syn) begin
      for (int i = 0; i < 8; i++) push_bit(m_tdr[i], 1);
      return;
    end
    push_bit(0, 0);
    for (int i = 0; i < n; i++) begin
      push_bit(m_tdr[i], 0);
      ones += m_tdr[i];
    end
    if (mp) push_bit(m_ctl[4], 0);
    else if (pe_on) push_bit(((ones % 2) == 1) ^ m_ctl[1], 0);
    push_bit(1, 0);
    if (m_ctl[2]) push_bit(1, 0);
  endfunction

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<100000", cycles);
      finish_up();
    end
    if (!rst_n) begin
      q.delete(); m_full = 0; m_ctl = '0; m_mctl = '0; exp_pins = 2'b11;
    end else begin
      if (q.size() != 0) void'(q.pop_front());
      else if (m_full && m_ctl[7]) begin
        build();
        m_full = 0;
      end
      exp_pins = (q.size() != 0) ? q[0] : 2'b11;
      if (wr_en) begin
        if (addr == 2'd0) m_ctl = wdata;
        if (addr == 2'd1) m_mctl = wdata;
        if (addr == 2'd3) begin m_tdr = wdata; m_full = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] act, exp;
      act = {tx_irq, sclk, txd};
      exp = {m_mctl[3] & ~m_full, exp_pins[1], exp_pins[0]};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s {tx_irq,sclk,txd} actual=%b expected=%b at %0t", cur, act, exp, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_tx();
    do @(posedge clk); while (q.size() != 0 || (m_full && m_ctl[7]));
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    rxd_drv = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit xon, input bit x, input bit stp);
    @(negedge clk);
    bit_out(0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (xon) bit_out(x);
    bit_out(stp);
    bit_out(1);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, v); chk("R1 status", v, 8'h10);
    rd(2'd0, v); chk("R1 control", v, 8'h20);
    chk("R1 pins", {4'b0, txd, sclk, rx_irq, tx_irq}, 8'h0C);

    // R3 plain 8N1, back to back, R14 tx irq enabled
    cur = "R3";
    wr(2'd1, 8'h08);
    wr(2'd0, 8'hE8);
    rd(2'd1, v); chk("R2 mode readback", v, 8'h08);
    wr(2'd3, 8'hA5);
    do @(posedge clk); while (m_full);
    wr(2'd3, 8'h3C);
    wait_tx();

    // R4 7-bit even parity two stops, then 8-bit odd parity
    cur = "R4";
    wr(2'd0, 8'hE5); wr(2'd3, 8'h5A); wait_tx();
    wr(2'd0, 8'hEB); wr(2'd3, 8'h3C); wait_tx();

    // R5 multiprocessor: parity ignored, length forced to 8, marker sent
    cur = "R5";
    wr(2'd1, 8'h09);
    wr(2'd0, 8'hF1); wr(2'd3, 8'h81); wait_tx();
    wr(2'd0, 8'hE1); wr(2'd3, 8'h7E); wait_tx();

    // R6 clocked mode with loopback
    cur = "R6";
    loop = 1'b1;
    wr(2'd1, 8'h0A);
    wr(2'd0, 8'hE8); wr(2'd3, 8'hC3); wait_tx();
    rd(2'd2, v); chk("R6 status after clocked transfer", v, 8'h18);
    rd(2'd3, v); chk("R6 looped byte", v, 8'hC3);
    loop = 1'b0;

    // R13 transmit disable mid-frame
    cur = "R13";
    wr(2'd1, 8'h08);
    wr(2'd3, 8'h96);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h68);
    wait_tx();
    wr(2'd3, 8'h11);
    repeat (300) @(negedge clk);
    rd(2'd2, v); chk("R13 byte held while disabled", v, 8'h00);
    wr(2'd0, 8'hE8);
    wait_tx();
    rd(2'd2, v); chk("R13 sent after re-enable", v, 8'h10);

    // R7 async receive, R14 rx irq
    cur = "R7";
    wr(2'd1, 8'h04);
    send(8'h96, 8, 0, 0, 1);
    rd(2'd2, v); chk("R7 status full", v, 8'h18);
    chk("R14 rx_irq on full", {7'b0, rx_irq}, 8'h01);
    rd(2'd3, v); chk("R7 data", v, 8'h96);
    rd(2'd2, v); chk("R7 full cleared by read", v, 8'h10);
    chk("R14 rx_irq off", {7'b0, rx_irq}, 8'h00);

    // R9 parity error, R11 clear
    cur = "R9";
    wr(2'd0, 8'hE9);
    send(8'h07, 8, 1, 0, 1);
    rd(2'd2, v); chk("R9 parity error", v, 8'h1C);
    rd(2'd3, v); chk("R9 data", v, 8'h07);
    send(8'h07, 8, 1, 1, 1);
    rd(2'd3, v); chk("R9 good parity data", v, 8'h07);
    wr(2'd0, 8'hE9);
    rd(2'd2, v); chk("R11 write one keeps flags", v, 8'h14);
    chk("R14 rx_irq on error", {7'b0, rx_irq}, 8'h01);
    wr(2'd0, 8'hC9);
    rd(2'd2, v); chk("R11 write zero clears", v, 8'h10);
    rd(2'd0, v); chk("R11 clear bit reads one", v, 8'hE9);

    // R8 framing error with two stop bits selected
    cur = "R8";
    wr(2'd0, 8'hEC);
    send(8'h55, 8, 0, 0, 0);
    rd(2'd2, v); chk("R8 framing error", v, 8'h19);
    rd(2'd3, v); chk("R8 data", v, 8'h55);
    wr(2'd0, 8'hC8);

    // R10 overrun
    cur = "R10";
    send(8'h11, 8, 0, 0, 1);
    send(8'h22, 8, 0, 0, 1);
    rd(2'd2, v); chk("R10 overrun", v, 8'h1A);
    rd(2'd3, v); chk("R10 older byte kept", v, 8'h11);
    wr(2'd0, 8'hC8);

    // R12 receive disable mid-frame
    cur = "R12";
    fork
      send(8'h3F, 8, 0, 0, 1);
      begin repeat (60) @(negedge clk); wr(2'd0, 8'hA8); end
    join
    rd(2'd2, v); chk("R12 frame in flight stored", v, 8'h18);
    rd(2'd3, v); chk("R12 data", v, 8'h3F);
    send(8'h44, 8, 0, 0, 1);
    rd(2'd2, v); chk("R12 later frame ignored", v, 8'h10);

    // R5 marker receive in multiprocessor mode
    cur = "R5";
    wr(2'd1, 8'h05);
    wr(2'd0, 8'hE8);
    send(8'hA0, 8, 1, 1, 1);
    rd(2'd2, v); chk("R5 address marker", v, 8'h38);
    rd(2'd3, v); chk("R5 data", v, 8'hA0);
    send(8'h0F, 8, 1, 0, 1);
    rd(2'd2, v); chk("R5 data marker", v, 8'h18);
    rd(2'd3, v); chk("R5 data 2", v, 8'h0F);

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule